// File: doc/BRIEF.md
# Bus-Programmed Serial DAC Loader

This block sits on a card's local register bus, where each access is marked by a data strobe. It accepts writes only when the slot address on the bus matches the card's own slot. The card's slot is given by geographic pins that are active low. The block keeps three registers: a loading enable, an active-low chip-select request, and a DAC data byte.

When loading is enabled and the chip-select request is active, a write to the data register starts a short serial sequence on a DAC chain. Chip select goes low, the most significant data bit is placed on the serial data line, and a single serial clock pulse clocks it in. The lines then return to their quiet levels.

An active-low system reset can arrive at any time. Its assertion takes effect at once, and its release is synchronised to the clock. It returns every register and every output to the power-up state.

Top module: `dacl_loader`

## Requirements
- R1: After reset the enable bit is 0, the chip-select request is 1 (inactive), and `dac_cs_n`=1, `dac_sclk`=0, `dac_sdata`=1.
- R2: An access is for this card only when `slot_addr` equals the bitwise inverse of `geo_n`; for example, `geo_n`=10000 matches slot 01111.
- R3: A strobed write to any other slot changes no register, and `dac_cs_n`, `dac_sclk` and `dac_sdata` stay at 1, 0 and 1.
- R4: The register select decodes as follows: 0000 writes the enable from `wr_data[2]`; 1000 writes the request from `wr_data[1]`, where 0 asserts it and 1 releases it; 0010 writes the data byte. Any other select code changes nothing.
- R5: A write is captured once, in the first clock cycle that sees `strobe` high after it was low, and only when `wr_n` is 0. Holding the strobe high does not capture the write again.
- R6: A data write starts a load only if the enable is 1 and the request is 0 at that moment. Otherwise the three outputs do not move.
- R7: Take the clock edge that captures the data write as edge 1. `dac_cs_n` is then low after edges 2 to 5 (the latch, clock-high, clock-low and quiesce states), and `dac_sclk` is high only after edge 3.
- R8: While chip select is low, `dac_sdata` carries bit 7 of the data just written and stays stable across the rising edge of `dac_sclk`. It returns to 1 when chip select rises.
- R9: A data write that arrives while a load is running neither restarts nor alters that load. A data write made after the block has returned to idle starts a new load.
- R10: Asserting `sys_rst_n` low, even in the middle of a load, immediately forces the outputs to their R1 values and clears all register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Active-low system reset, asynchronous assert |
| geo_n | input | 5 | Active-low geographic slot pins |
| slot_addr | input | 5 | Slot field of the bus address |
| reg_sel | input | 4 | Register select field of the bus address |
| wr_data | input | 8 | Write data byte |
| strobe | input | 1 | Data strobe marking a bus cycle |
| wr_n | input | 1 | Write qualifier, 0 = write |
| dac_cs_n | output | 1 | DAC chain chip select, active low |
| dac_sclk | output | 1 | DAC serial clock |
| dac_sdata | output | 1 | Serial data to the first DAC |

## Verification
On every cycle, the assertions check the following:
- the serial clock pulse lasts one cycle and sits inside chip select;
- the data line is stable at that pulse and returns high when chip select is released;
- a load starts only from idle, and only when the enable and request registers allowed it;
- a write to a foreign slot or a held strobe leaves the registers unchanged.

Several behaviours can only be shown by the bench scenarios. These are the exact cycle positions of the sequence, the slot match swept over every slot code for two geographic settings, and the register-select decode. The bench also shows that registers are cleared by a reset taken in the middle of a load. It does this by observing afterwards that a data write no longer starts a sequence.

// File: rtl/dacl_pkg.sv
package dacl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE          = 3'd0,
    ST_LATCH_1       = 3'd1,
    ST_LATCH_2       = 3'd2,
    ST_IO_1          = 3'd3,
    ST_IO_2          = 3'd4,
    ST_SET_QUIESCENT = 3'd5
  } seq_state_t;

endpackage

// File: rtl/dacl_rst_sync.sv
module dacl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/dacl_slot_match.sv
module dacl_slot_match #(
  parameter int unsigned SLOT_W = 5
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] geo_n_i,
  output logic              hit_o
);

  logic [SLOT_W-1:0] bit_ok;

  for (genvar gi = 0; gi < SLOT_W; gi++) begin : g_bit
    // a slot bit agrees when it is the inverse of the active-low pin
    assign bit_ok[gi] = slot_i[gi] ^ geo_n_i[gi];
  end

  assign hit_o = &bit_ok;

endmodule

// File: rtl/dacl_regs.sv
module dacl_regs #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned EN_BIT  = 2,
  parameter int unsigned REQ_BIT = 1,
  parameter logic [SEL_W-1:0] SEL_CTRL_EN  = 4'b0000,
  parameter logic [SEL_W-1:0] SEL_CTRL_REQ = 4'b1000,
  parameter logic [SEL_W-1:0] SEL_DATA     = 4'b0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              wr_n_i,
  input  logic              hit_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic              req_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_wr_o
);

  logic              strobe_q;
  logic              en_q;
  logic              req_n_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              wr_en_reg;
  logic              wr_req_reg;
  logic              wr_data_reg;

  // one capture per strobe: only the low-to-high step qualifies
  always_comb begin
    accept      = strobe_i & ~strobe_q & hit_i & ~wr_n_i;
    wr_en_reg   = accept & (sel_i == SEL_CTRL_EN);
    wr_req_reg  = accept & (sel_i == SEL_CTRL_REQ);
    wr_data_reg = accept & (sel_i == SEL_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      en_q     <= 1'b0;
      req_n_q  <= 1'b1;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (wr_en_reg) begin
        en_q <= wdata_i[EN_BIT];
      end
      if (wr_req_reg) begin
        req_n_q <= wdata_i[REQ_BIT];
      end
      if (wr_data_reg) begin
        data_q <= wdata_i;
      end
    end
  end

  assign en_o      = en_q;
  assign req_n_o   = req_n_q;
  assign data_o    = data_q;
  assign data_wr_o = wr_data_reg;

  AST_FOREIGN_SLOT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> ($stable(en_q) && $stable(req_n_q) && $stable(data_q))) // R3
    else $error("register changed on foreign slot");

  AST_HELD_STROBE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && strobe_q) |=> ($stable(en_q) && $stable(req_n_q) && $stable(data_q))) // R5
    else $error("register changed while strobe held");

endmodule

// File: rtl/dacl_seq.sv
module dacl_seq
  import dacl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic bit_i,
  output logic cs_n_o,
  output logic sclk_o,
  output logic sdata_o
);

  seq_state_t state_q;
  seq_state_t state_d;
  logic       cs_n_q;
  logic       cs_n_d;
  logic       sclk_q;
  logic       sclk_d;
  logic       sdata_q;
  logic       sdata_d;
  logic       active_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:          if (go_i) state_d = ST_LATCH_1;
      ST_LATCH_1:       state_d = ST_LATCH_2;
      ST_LATCH_2:       state_d = ST_IO_1;
      ST_IO_1:          state_d = ST_IO_2;
      ST_IO_2:          state_d = ST_SET_QUIESCENT;
      ST_SET_QUIESCENT: state_d = ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  // outputs registered from the next state so pins come straight off flops
  always_comb begin
    active_d = (state_d == ST_LATCH_2) || (state_d == ST_IO_1) ||
               (state_d == ST_IO_2)    || (state_d == ST_SET_QUIESCENT);
    cs_n_d   = ~active_d;
    sclk_d   = (state_d == ST_IO_1);
    if (state_d == ST_LATCH_2) begin
      sdata_d = bit_i;
    end else if (active_d) begin
      sdata_d = sdata_q;
    end else begin
      sdata_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      sdata_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      sdata_q <= sdata_d;
    end
  end

  assign cs_n_o  = cs_n_q;
  assign sclk_o  = sclk_q;
  assign sdata_o = sdata_q;

  AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_n_q) // R7
    else $error("serial clock high outside chip select");

  AST_SCLK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |=> !sclk_q) // R7
    else $error("serial clock high for more than one cycle");

  AST_SDATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(sdata_q)) // R8
    else $error("serial data moved at clock rise");

  AST_SDATA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> sdata_q) // R8
    else $error("serial data not high at chip select release");

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LATCH_1) |-> ($past(state_q) == ST_IDLE)) // R9
    else $error("sequence restarted while busy");

endmodule

// File: rtl/dacl_loader.sv
module dacl_loader #(
  parameter int unsigned SLOT_W  = 5,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned EN_BIT  = 2,
  parameter int unsigned REQ_BIT = 1,
  parameter logic [SEL_W-1:0] SEL_CTRL_EN  = 4'b0000,
  parameter logic [SEL_W-1:0] SEL_CTRL_REQ = 4'b1000,
  parameter logic [SEL_W-1:0] SEL_DATA     = 4'b0010
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic [SLOT_W-1:0] geo_n,
  input  logic [SLOT_W-1:0] slot_addr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              strobe,
  input  logic              wr_n,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdata
);

  localparam int unsigned MSB = DATA_W - 1;

  logic              rst_n;
  logic              slot_hit;
  logic              en;
  logic              req_n;
  logic [DATA_W-1:0] data_byte;
  logic              data_wr;
  logic              load_go;
  logic              unused_data_low;

  dacl_rst_sync u_rst (
    .clk    (clk),
    .arst_n (sys_rst_n),
    .rst_n  (rst_n)
  );

  dacl_slot_match #(.SLOT_W(SLOT_W)) u_slot (
    .slot_i  (slot_addr),
    .geo_n_i (geo_n),
    .hit_o   (slot_hit)
  );

  dacl_regs #(
    .SEL_W        (SEL_W),
    .DATA_W       (DATA_W),
    .EN_BIT       (EN_BIT),
    .REQ_BIT      (REQ_BIT),
    .SEL_CTRL_EN  (SEL_CTRL_EN),
    .SEL_CTRL_REQ (SEL_CTRL_REQ),
    .SEL_DATA     (SEL_DATA)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (strobe),
    .wr_n_i    (wr_n),
    .hit_i     (slot_hit),
    .sel_i     (reg_sel),
    .wdata_i   (wr_data),
    .en_o      (en),
    .req_n_o   (req_n),
    .data_o    (data_byte),
    .data_wr_o (data_wr)
  );

  // gate the start on the register values in force at the write
  assign load_go         = data_wr & en & ~req_n;
  assign unused_data_low = ^data_byte[MSB-1:0];

  dacl_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (load_go),
    .bit_i   (data_byte[MSB]),
    .cs_n_o  (dac_cs_n),
    .sclk_o  (dac_sclk),
    .sdata_o (dac_sdata)
  );

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_cs_n) |-> ($past(en, 2) && !$past(req_n, 2))) // R6
    else $error("load started without enable and request");

endmodule

// File: tb/sim_dacl_loader.sv
module sim_dacl_loader;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] GEO_A = 5'b10000;
  localparam logic [4:0] GEO_B = 5'b00101;

  logic       clk;
  logic       sys_rst_n;
  logic [4:0] geo_n;
  logic [4:0] slot_addr;
  logic [3:0] reg_sel;
  logic [7:0] wr_data;
  logic       strobe;
  logic       wr_n;
  logic       dac_cs_n;
  logic       dac_sclk;
  logic       dac_sdata;

  int n_checks;
  int n_fails;
  bit done;

  dacl_loader u0 (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .geo_n     (geo_n),
    .slot_addr (slot_addr),
    .reg_sel   (reg_sel),
    .wr_data   (wr_data),
    .strobe    (strobe),
    .wr_n      (wr_n),
    .dac_cs_n  (dac_cs_n),
    .dac_sclk  (dac_sclk),
    .dac_sdata (dac_sdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [4:0] my_slot();
    return ~geo_n;
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s at %0t: {cs_n,sclk,sdata} actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic chk_pins(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {dac_cs_n, dac_sclk, dac_sdata};
    chk(act === exp, req, act, exp);
  endtask

  // expected pins k cycles after the capturing edge
  function automatic logic [2:0] seq_exp(input int k, input bit run, input bit msb);
    bit act;
    act = run && (k >= 2) && (k <= 5);
    return {~act, run && (k == 3), act ? msb : 1'b1};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    sys_rst_n = 1'b0;
    strobe    = 1'b0;
    wr_n      = 1'b1;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [4:0] slot, input logic [3:0] sel, input logic [7:0] d, input logic wrn);
    @(negedge clk);
    slot_addr = slot;
    reg_sel   = sel;
    wr_data   = d;
    wr_n      = wrn;
    strobe    = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (8) @(negedge clk);
    wr_n = 1'b1;
  endtask

  // data write with the whole expected waveform checked cycle by cycle
  task automatic load_chk(input logic [4:0] slot, input logic [7:0] d, input logic wrn,
                          input bit run, input string req);
    @(negedge clk);
    slot_addr = slot;
    reg_sel   = 4'b0010;
    wr_data   = d;
    wr_n      = wrn;
    strobe    = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk_pins(req, seq_exp(k, run, d[7]));
      if (k == 4) strobe = 1'b0;
    end
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic arm(input logic [4:0] slot, input bit en, input bit reqn);
    bus_wr(slot, 4'b0000, {5'b0, en, 2'b0}, 1'b0);
    bus_wr(slot, 4'b1000, {6'b0, reqn, 1'b0}, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      report();
    end
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    done      = 1'b0;
    sys_rst_n = 1'b0;
    geo_n     = GEO_A;
    slot_addr = 5'b0;
    reg_sel   = 4'b0;
    wr_data   = 8'h00;
    strobe    = 1'b0;
    wr_n      = 1'b1;

    // R1: power-up pins during reset and after release
    repeat (2) @(negedge clk);
    chk_pins("R1", 3'b101);
    sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_pins("R1", 3'b101);
    load_chk(my_slot(), 8'h80, 1'b0, 1'b0, "R1");
    bus_wr(my_slot(), 4'b0000, 8'h04, 1'b0);
    load_chk(my_slot(), 8'h80, 1'b0, 1'b0, "R1");

    // R6 / R4: every enable and request combination
    for (int c = 0; c < 4; c++) begin
      do_reset();
      arm(my_slot(), c[1], c[0]);
      load_chk(my_slot(), 8'h80, 1'b0, (c[1] == 1'b1) && (c[0] == 1'b0), "R6");
    end

    // R2 / R3: sweep every slot code for two geographic settings
    for (int g = 0; g < 2; g++) begin
      geo_n = (g == 0) ? GEO_A : GEO_B;
      for (int s = 0; s < 32; s++) begin
        do_reset();
        arm(5'(s), 1'b1, 1'b0);
        load_chk(5'(s), 8'hC3, 1'b0, 5'(s) == my_slot(), (5'(s) == my_slot()) ? "R2" : "R3");
      end
    end
    geo_n = GEO_A;

    // R7 / R8: waveform for several data patterns
    do_reset();
    arm(my_slot(), 1'b1, 1'b0);
    load_chk(my_slot(), 8'h00, 1'b0, 1'b1, "R8");
    load_chk(my_slot(), 8'hFF, 1'b0, 1'b1, "R8");
    load_chk(my_slot(), 8'h7F, 1'b0, 1'b1, "R7");
    load_chk(my_slot(), 8'h80, 1'b0, 1'b1, "R7");
    load_chk(my_slot(), 8'h55, 1'b0, 1'b1, "R8");
    load_chk(my_slot(), 8'hAA, 1'b0, 1'b1, "R8");

    // R5: read-direction cycles capture nothing
    load_chk(my_slot(), 8'h80, 1'b1, 1'b0, "R5");
    bus_wr(my_slot(), 4'b0000, 8'h00, 1'b1);
    load_chk(my_slot(), 8'h80, 1'b0, 1'b1, "R5");

    // R4: undecoded selects change nothing; request release blocks loads
    bus_wr(my_slot(), 4'b0100, 8'h00, 1'b0);
    bus_wr(my_slot(), 4'b0001, 8'h00, 1'b0);
    load_chk(my_slot(), 8'h80, 1'b0, 1'b1, "R4");
    bus_wr(my_slot(), 4'b1000, 8'h02, 1'b0);
    load_chk(my_slot(), 8'h80, 1'b0, 1'b0, "R4");
    bus_wr(my_slot(), 4'b1000, 8'h00, 1'b0);
    bus_wr(my_slot(), 4'b0000, 8'h00, 1'b0);
    load_chk(my_slot(), 8'h80, 1'b0, 1'b0, "R4");
    bus_wr(my_slot(), 4'b0000, 8'h04, 1'b0);

    // R9: second write during a load is ignored by the sequencer
    @(negedge clk);
    slot_addr = my_slot();
    reg_sel   = 4'b0010;
    wr_data   = 8'h80;
    wr_n      = 1'b0;
    strobe    = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk_pins("R9", seq_exp(k, 1'b1, 1'b1));
      if (k == 1) strobe = 1'b0;
      if (k == 2) begin
        wr_data = 8'h00;
        strobe  = 1'b1;
      end
      if (k == 3) strobe = 1'b0;
    end
    wr_n = 1'b1;
    load_chk(my_slot(), 8'h00, 1'b0, 1'b1, "R9");

    // R10: reset in the middle of a load
    @(negedge clk);
    slot_addr = my_slot();
    reg_sel   = 4'b0010;
    wr_data   = 8'h80;
    wr_n      = 1'b0;
    strobe    = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk_pins("R7", seq_exp(k, 1'b1, 1'b1));
    end
    sys_rst_n = 1'b0;
    #1;
    chk_pins("R10", 3'b101);
    repeat (2) @(negedge clk);
    chk_pins("R10", 3'b101);
    strobe    = 1'b0;
    wr_n      = 1'b1;
    sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_pins("R10", 3'b101);
    load_chk(my_slot(), 8'h80, 1'b0, 1'b0, "R10");
    bus_wr(my_slot(), 4'b0000, 8'h04, 1'b0);
    load_chk(my_slot(), 8'h80, 1'b0, 1'b0, "R10");

    done = 1'b1;
    report();
  end

endmodule